// File: doc/BRIEF.md
# Two-Bit Hysteresis Branch Direction Predictor

This block guesses whether the next conditional branch will be taken. It holds a small direct-indexed table of two-bit predictor entries. The low bits of a branch address pick the entry. Each entry stores two bits: the direction it currently predicts, and the outcome of the most recent branch that was resolved into it. Because of this, a prediction reverses only after two wrong guesses in a row. A single wrong guess followed by a correct one leaves the prediction where it was.

The lookup port reads combinationally. The entry selected by the lookup address drives the guess in the same cycle. When a branch resolves, the pipeline raises the update strobe with the branch address and the real outcome. The selected entry moves to its next state on the following rising clock edge. Synchronous reset returns every entry to the strongly-not-taken state. The table size is a power of two, and the default is 16 entries.

Top module: `hyst_predictor`

## Requirements
- R1: One cycle after synchronous reset (`rst` high at a rising edge), every entry is in state 0, and `pred_taken` is 0 for every lookup address.
- R2: `pred_taken` is the high bit of the entry selected by the low log2(ENTRIES) bits of `look_pc`. The state encoding is 0 strong not-taken, 1 weak not-taken, 2 weak taken and 3 strong taken, so states 2 and 3 predict taken. Taken is encoded as 1.
- R3: A strong entry keeps its prediction for either outcome. State 0 goes to 1 on taken and stays 0 on not taken. State 3 goes to 2 on not taken and stays 3 on taken.
- R4: A weak entry jumps straight to the strong state on the side of the outcome. State 1 or 2 goes to 3 on taken and to 0 on not taken.
- R5: After any update, the low state bit of the written entry equals the outcome that was applied.
- R6: While `upd_valid` is 0, no entry changes, whatever values `upd_pc` and `upd_taken` hold.
- R7: An update changes only the entry selected by the low index bits of `upd_pc`. Upper address bits are ignored, so aliasing addresses share an entry.
- R8: When a lookup and an update select the same entry in one cycle, `pred_taken` shows the state from before the update. The new state becomes visible in the next cycle.
- R9: Starting from strong taken, two not-taken outcomes in a row flip the prediction to not taken. A not-taken outcome followed by a taken outcome leaves it predicting taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| look_pc | input | ADDR_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |

## Verification
The only visible output is the prediction bit. A corrupted outcome bit therefore stays hidden until the next update to that entry, which then lands on the wrong side. A single not-taken probe after each update makes this show up within two cycles. A wrong high bit, a write to the wrong entry, or a write while the strobe is low shows up in the very next lookup of the affected entry. For this reason the bench sweeps every entry through every state and outcome, and it probes both the written entry and a neighbour.

// File: rtl/hyst_bp_pkg.sv
package hyst_bp_pkg;

  typedef enum logic [1:0] {
    ST_FIRM_NT = 2'd0,
    ST_SOFT_NT = 2'd1,
    ST_SOFT_T  = 2'd2,
    ST_FIRM_T  = 2'd3
  } hyst_state_e;

  // New guess bit: pinned in strong states, follows the outcome in weak states.
  function automatic hyst_state_e hyst_advance(hyst_state_e cur, logic taken);
    logic hi;
    hi = (cur[1] & cur[0]) | (taken & (cur[1] | cur[0]));
    return hyst_state_e'({hi, taken});
  endfunction

  function automatic logic hyst_guess(hyst_state_e s);
    return s[1];
  endfunction

  function automatic logic hyst_is_soft(hyst_state_e s);
    return s[1] ^ s[0];
  endfunction

endpackage

// File: rtl/hyst_next.sv
module hyst_next
  import hyst_bp_pkg::*;
(
  input  hyst_state_e cur,
  input  logic        taken,
  output hyst_state_e nxt,
  output logic        flips
);
  always_comb begin
    nxt   = hyst_advance(cur, taken);
    flips = hyst_guess(nxt) ^ hyst_guess(cur);
  end
endmodule

// File: rtl/hyst_table.sv
module hyst_table
  import hyst_bp_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  hyst_state_e        wr_state,
  input  logic [IDX_W-1:0]   rd_look_idx,
  output hyst_state_e        rd_look_state,
  input  logic [IDX_W-1:0]   rd_upd_idx,
  output hyst_state_e        rd_upd_state,
  output logic [ENTRIES-1:0] wr_sel
);
  hyst_state_e ent [ENTRIES];

  always_comb begin
    wr_sel = '0;
    if (wr_en) wr_sel[wr_idx] = 1'b1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)            ent[g] <= ST_FIRM_NT;
      else if (wr_sel[g]) ent[g] <= wr_state;
    end
  end

  assign rd_look_state = ent[rd_look_idx];
  assign rd_upd_state  = ent[rd_upd_idx];
endmodule

// File: rtl/hyst_predictor.sv
module hyst_predictor
  import hyst_bp_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] look_pc,
  output logic              pred_taken
);
  localparam int IDX_W = $clog2(ENTRIES);

  // Named internal events, observed by the bound checker.
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [IDX_W-1:0]   look_idx;
  hyst_state_e        upd_cur;
  hyst_state_e        upd_nxt;
  hyst_state_e        look_state;
  logic               upd_flip;
  logic [ENTRIES-1:0] wr_sel;

  assign wr_en    = upd_valid & ~rst;
  assign wr_idx   = upd_pc[IDX_W-1:0];
  assign look_idx = look_pc[IDX_W-1:0];

  hyst_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_state      (upd_nxt),
    .rd_look_idx   (look_idx),
    .rd_look_state (look_state),
    .rd_upd_idx    (wr_idx),
    .rd_upd_state  (upd_cur),
    .wr_sel        (wr_sel)
  );

  hyst_next u_next (
    .cur   (upd_cur),
    .taken (upd_taken),
    .nxt   (upd_nxt),
    .flips (upd_flip)
  );

  assign pred_taken = hyst_guess(look_state);
endmodule

// File: rtl/hyst_predictor_chk.sv
module hyst_predictor_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               upd_taken,
  input logic               pred_taken,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [IDX_W-1:0]   look_idx,
  input logic [1:0]         upd_cur,
  input logic [1:0]         look_state,
  input logic               upd_flip,
  input logic [ENTRIES-1:0] wr_sel
);
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (look_state == 2'd0 && !pred_taken));

  a_r3_strong_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (upd_cur == 2'd0 || upd_cur == 2'd3)) |-> !upd_flip);

  a_r4_soft_jumps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (upd_cur == 2'd1 || upd_cur == 2'd2)) |=>
      (look_idx != $past(wr_idx) || look_state == {2{$past(upd_taken)}}));

  a_r5_low_is_outcome: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (look_idx != $past(wr_idx) || look_state[0] == $past(upd_taken)));

  a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(look_idx)) |-> $stable(look_state));

  a_r7_one_entry: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel) && ($countones(wr_sel) == 32'(wr_en)));

  a_r8_old_value: assert property (@(posedge clk) disable iff (rst)
    (wr_en && look_idx == wr_idx) |-> (pred_taken == upd_cur[1]));
endmodule

bind hyst_predictor hyst_predictor_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/hyst_predictor_tb.sv
module hyst_predictor_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] look_pc = '0;
  logic        pred_taken;

  int errors = 0;
  int checks = 0;
  int model [N];
  bit done = 0;

  always #4 clk = ~clk;

  hyst_predictor #(.ENTRIES(N), .ADDR_W(32)) u_dut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .look_pc(look_pc), .pred_taken(pred_taken)
  );

  // Independent restatement of the transition rule.
  function automatic int bench_next(int s, int t);
    if (s == 0) return t;
    if (s == 3) return 2 + t;
    return 3 * t;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] pc, input logic t,
                      input logic [31:0] lpc, input string tag);
    @(negedge clk);
    upd_valid = v; upd_pc = pc; upd_taken = t; look_pc = lpc;
    #1;
    chk(tag, pred_taken, logic'(model[lpc % N] >= 2));
    @(posedge clk);
    if (v) model[pc % N] = bench_next(model[pc % N], int'(t));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; upd_valid = 1'b0;
    @(posedge clk);
    for (int i = 0; i < N; i++) model[i] = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reach(input logic [31:0] pc, input int s);
    logic [31:0] other;
    other = pc + 1;
    if (s == 1) step(1, pc, 1, other, "R2");
    if (s >= 2) begin
      step(1, pc, 1, other, "R2");
      step(1, pc, 1, other, "R2");
    end
    if (s == 2) step(1, pc, 0, other, "R2");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 0;
    repeat (2) @(posedge clk);
    do_reset();

    // R1: dirty some entries, reset, all read not-taken
    for (int i = 0; i < N; i += 3) step(1, i, 1, 0, "R2");
    do_reset();
    for (int i = 0; i < N; i++) step(0, 0, 0, i, "R1");

    // Exhaustive sweep: every entry, start state, outcome
    for (int idx = 0; idx < N; idx++) begin
      for (int s = 0; s < 4; s++) begin
        for (int t = 0; t < 2; t++) begin
          logic [31:0] pc;
          pc = 32'(idx) + 32'h0001_0000 * 32'(s);
          do_reset();
          reach(pc, s);
          step(1, pc, logic'(t), pc, "R8");
          step(0, 0, 0, pc, (s == 0 || s == 3) ? "R3" : "R4");
          step(0, 0, 0, pc + 1, "R7");
          // probe low bit through an aliasing address
          step(1, pc ^ 32'h4000_0000, 0, pc, "R7");
          step(0, 0, 0, pc, "R5");
        end
      end
    end

    // R6: strobe low leaves the table alone
    do_reset();
    reach(32'd5, 3);
    reach(32'd9, 1);
    for (int k = 0; k < 6; k++) step(0, 32'(k % 2 ? 5 : 9), logic'(k % 2), 5, "R6");
    for (int i = 0; i < N; i++) step(0, 0, 0, i, "R6");

    // R9: two wrong guesses flip, wrong-then-right does not
    do_reset();
    reach(32'd7, 3);
    step(1, 7, 0, 7, "R9");
    step(1, 7, 0, 7, "R9");
    step(0, 0, 0, 7, "R9");
    chk("R9", pred_taken, 1'b0);
    do_reset();
    reach(32'd7, 3);
    step(1, 7, 0, 7, "R9");
    step(1, 7, 1, 7, "R9");
    step(0, 0, 0, 7, "R9");
    chk("R9", pred_taken, 1'b1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule